// File: doc/BRIEF.md
# Mailbox Message Client Sequencer

This block is the requesting side of a closed-loop word handshake between two processing subsystems that share an LED register. When a button press is seen while idle, it offers a button-pressed message on an outgoing mailbox word port. It then waits for an acknowledgement word on the incoming mailbox port. After that acknowledgement it writes the shared LED register once and offers an LED-ready message. It finishes after a second acknowledgement. Any reply other than the exact acknowledgement ends the exchange with a one-cycle error pulse. A wait that lasts too long returns the block to idle and sets a sticky timeout flag.

Every message is one 32-bit word of four ASCII bytes, with the lowest byte sent first: a type letter, the processor digit, a data digit and a terminating null. The processor number is a parameter from 0 to 9. The mailbox queues and the LED peripheral sit outside the block. They appear only as a queue-empty flag, a data-present flag, a word strobe in each direction and an LED write strobe.

Top module: `mbox_client_seq`

## Requirements
- R1: After reset, tx_valid_o, rx_pop_o, led_we_o, busy_o, err_o, done_o and timeout_o are all 0.
- R2: Word layout is bits [7:0] type letter, [15:8] ASCII digit 0x30+PROC_ID, [23:16] data, [31:24] 0x00. The button message is 'B' (0x42) with data '0' (0x30), and the LED-ready message is 'L' (0x4C) with data '0'.
- R3: A button press while idle makes the block offer the 'B' word with tx_valid_o in the next cycle. tx_valid_o is high only while tx_empty_i is high, and the word counts as sent in each cycle in which tx_valid_o is high.
- R4: rx_pop_o is high only while rx_avail_i is high and a reply is awaited. The word on rx_word_i in that cycle is the reply that is consumed.
- R5: The accepted reply is exactly 'A', 0x30+PROC_ID, 'A', 0x00. When it answers the 'B' message, led_we_o is high for one cycle, in the next cycle, with led_wdata_o equal to led_value_i. The 'L' word is offered in the cycle after that.
- R6: led_we_o is never high while a reply is awaited, and never high after a rejected reply.
- R7: When the accepted reply answers the 'L' message, the block returns to idle and done_o pulses for one cycle in the next cycle.
- R8: Any other reply (NACK 'N', another type, wrong processor digit, wrong byte 2, non-zero byte 3) returns the block to idle. err_o pulses for one cycle in the next cycle.
- R9: If the block spends TIMEOUT_CYC cycles in a send or wait state without progress, it returns to idle and sets timeout_o. timeout_o stays set until reset.
- R10: busy_o is high exactly while an exchange is in progress and low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 1 | Debounced button press |
| led_value_i | input | LED_W | Value to place in the shared LED register |
| tx_empty_i | input | 1 | Outgoing mailbox queue is empty |
| tx_valid_o | output | 1 | Outgoing word strobe |
| tx_word_o | output | 32 | Outgoing message word |
| rx_avail_i | input | 1 | Incoming mailbox queue holds a word |
| rx_word_i | input | 32 | Incoming message word |
| rx_pop_o | output | 1 | Consume the incoming word |
| led_we_o | output | 1 | Shared LED register write strobe |
| led_wdata_o | output | LED_W | Shared LED register write data |
| busy_o | output | 1 | Exchange in progress |
| err_o | output | 1 | One-cycle pulse on a rejected reply |
| done_o | output | 1 | One-cycle pulse on a completed exchange |
| timeout_o | output | 1 | Sticky wait-timeout flag |

## Verification
The strobes tx_valid_o, rx_pop_o and led_we_o are decoded from the state register and the present inputs. They are therefore due in the same cycle as the inputs that enable them, and the bench samples them one time step after it drives those inputs, at the falling edge. Each state move takes one rising edge. The bench steps through the sequence one edge at a time: the 'B' word one edge after the press, the LED write one edge after the accepted reply, and the 'L' word one edge after that. err_o and done_o are registered, so the bench expects them exactly one edge after the reply is consumed and checks that they are low again one edge later. The timeout is checked on both sides of its boundary: still busy after TIMEOUT_CYC-1 edges in the wait state, idle with timeout_o set after TIMEOUT_CYC edges.

// File: rtl/mbox_msg_pkg.sv
package mbox_msg_pkg;

  localparam int WORD_W = 32;

  localparam logic [7:0] CH_BUTTON = 8'h42;  // 'B'
  localparam logic [7:0] CH_LEDRDY = 8'h4C;  // 'L'
  localparam logic [7:0] CH_ACK    = 8'h41;  // 'A'
  localparam logic [7:0] CH_ZERO   = 8'h30;  // '0'
  localparam logic [7:0] CH_NULL   = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_BTN,
    ST_WAIT_ACK1,
    ST_LED_WR,
    ST_SEND_LED,
    ST_WAIT_ACK2
  } seq_state_e;

  typedef enum logic {
    MSG_BUTTON,
    MSG_LED_READY
  } msg_kind_e;

  function automatic logic [7:0] digit_of(input int unsigned num);
    digit_of = CH_ZERO + 8'(num);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [7:0] kind,
                                                  input logic [7:0] who,
                                                  input logic [7:0] data);
    pack_word = {CH_NULL, data, who, kind};
  endfunction

endpackage

// File: rtl/mbox_msg_encoder.sv
module mbox_msg_encoder
  import mbox_msg_pkg::*;
#(
  parameter int unsigned PROC_ID = 0
) (
  input  msg_kind_e          kind_i,
  output logic [WORD_W-1:0]  word_o
);

  localparam logic [7:0] SELF_DIGIT = digit_of(PROC_ID);

  logic [7:0] type_ch;

  always_comb begin
    type_ch = (kind_i == MSG_LED_READY) ? CH_LEDRDY : CH_BUTTON;
    word_o  = pack_word(type_ch, SELF_DIGIT, CH_ZERO);
  end

endmodule

// File: rtl/mbox_reply_checker.sv
module mbox_reply_checker
  import mbox_msg_pkg::*;
#(
  parameter int unsigned PROC_ID = 0
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              is_ack_o
);

  localparam logic [7:0] SELF_DIGIT = digit_of(PROC_ID);

  logic [7:0] b_type, b_who, b_data, b_term;

  always_comb begin
    b_type   = word_i[7:0];
    b_who    = word_i[15:8];
    b_data   = word_i[23:16];
    b_term   = word_i[31:24];
    is_ack_o = (b_type == CH_ACK) && (b_who == SELF_DIGIT) &&
               (b_data == CH_ACK) && (b_term == CH_NULL);
  end

endmodule

// File: rtl/mbox_wait_timer.sv
module mbox_wait_timer #(
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_i || (cnt_q != '0);
    if (!run_i || restart_i) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
    expired_o = run_i && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: a single wait never counts past its limit
  p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/mbox_client_seq.sv
module mbox_client_seq
  import mbox_msg_pkg::*;
#(
  parameter int unsigned PROC_ID     = 0,
  parameter int unsigned LED_W       = 4,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_i,
  input  logic [LED_W-1:0]  led_value_i,
  input  logic              tx_empty_i,
  output logic              tx_valid_o,
  output logic [31:0]       tx_word_o,
  input  logic              rx_avail_i,
  input  logic [31:0]       rx_word_i,
  output logic              rx_pop_o,
  output logic              led_we_o,
  output logic [LED_W-1:0]  led_wdata_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam logic [31:0] ACK_WORD = pack_word(CH_ACK, digit_of(PROC_ID), CH_ACK);

  initial begin
    a_proc_id_range: assert (PROC_ID <= 9);
  end

  seq_state_e state_q, state_d;
  msg_kind_e  kind;
  logic       reply_ok;
  logic       waiting, expired;
  logic       bad_set, done_set, tmo_set;
  logic       err_q, done_q, tmo_q;

  mbox_msg_encoder #(.PROC_ID(PROC_ID)) u_enc (
    .kind_i (kind),
    .word_o (tx_word_o)
  );

  mbox_reply_checker #(.PROC_ID(PROC_ID)) u_chk (
    .word_i   (rx_word_i),
    .is_ack_o (reply_ok)
  );

  mbox_wait_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (waiting),
    .restart_i (state_d != state_q),
    .expired_o (expired)
  );

  // next-state and strobe decode
  always_comb begin
    state_d    = state_q;
    kind       = MSG_BUTTON;
    tx_valid_o = 1'b0;
    rx_pop_o   = 1'b0;
    led_we_o   = 1'b0;
    waiting    = 1'b0;
    bad_set    = 1'b0;
    done_set   = 1'b0;
    tmo_set    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (btn_i) state_d = ST_SEND_BTN;
      end
      ST_SEND_BTN, ST_SEND_LED: begin
        waiting = 1'b1;
        kind    = (state_q == ST_SEND_LED) ? MSG_LED_READY : MSG_BUTTON;
        if (tx_empty_i) begin
          tx_valid_o = 1'b1;
          state_d    = (state_q == ST_SEND_LED) ? ST_WAIT_ACK2 : ST_WAIT_ACK1;
        end else if (expired) begin
          tmo_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_ACK1, ST_WAIT_ACK2: begin
        waiting = 1'b1;
        if (rx_avail_i) begin
          rx_pop_o = 1'b1;
          if (!reply_ok) begin
            bad_set = 1'b1;
            state_d = ST_IDLE;
          end else if (state_q == ST_WAIT_ACK1) begin
            state_d = ST_LED_WR;
          end else begin
            done_set = 1'b1;
            state_d  = ST_IDLE;
          end
        end else if (expired) begin
          tmo_set = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_LED_WR: begin
        led_we_o = 1'b1;
        state_d  = ST_SEND_LED;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state and status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= bad_set;
      done_q  <= done_set;
      if (tmo_set) tmo_q <= 1'b1;
    end
  end

  assign led_wdata_o = led_value_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign err_o       = err_q;
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;

  // R3: a word is offered only into an empty outgoing queue
  p_tx_into_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> tx_empty_i);

  // R2: every outgoing word ends with a null byte
  p_tx_null_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> (tx_word_o[31:24] == 8'h00));

  // R4: a reply is consumed only when one is present
  p_pop_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_o |-> rx_avail_i);

  // R5/R6: the LED write follows directly on an accepted reply
  p_led_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    led_we_o |-> $past(rx_pop_o && (rx_word_i == ACK_WORD)));

  // R6: no LED write while a word is being offered or consumed
  p_led_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    led_we_o |-> !(tx_valid_o || rx_pop_o));

  // R8: the error flag is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R9: the timeout flag never clears on its own
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o);

  // R7: completion and error never coincide
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

endmodule

// File: tb/mbox_client_seq_tb.sv
module mbox_client_seq_tb;

  localparam int unsigned PROC_ID = 3;
  localparam int unsigned LED_W   = 4;
  localparam int unsigned TMO     = 20;

  localparam logic [31:0] W_BTN  = 32'h0030_3342;
  localparam logic [31:0] W_LED  = 32'h0030_334C;
  localparam logic [31:0] W_ACK  = 32'h0041_3341;
  localparam logic [31:0] W_NACK = 32'h004E_334E;
  localparam logic [31:0] W_ACK5 = 32'h0041_3541;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             btn_i;
  logic [LED_W-1:0] led_value_i;
  logic             tx_empty_i;
  logic             tx_valid_o;
  logic [31:0]      tx_word_o;
  logic             rx_avail_i;
  logic [31:0]      rx_word_i;
  logic             rx_pop_o;
  logic             led_we_o;
  logic [LED_W-1:0] led_wdata_o;
  logic             busy_o, err_o, done_o, timeout_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mbox_client_seq #(.PROC_ID(PROC_ID), .LED_W(LED_W), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .led_value_i(led_value_i),
    .tx_empty_i(tx_empty_i), .tx_valid_o(tx_valid_o), .tx_word_o(tx_word_o),
    .rx_avail_i(rx_avail_i), .rx_word_i(rx_word_i), .rx_pop_o(rx_pop_o),
    .led_we_o(led_we_o), .led_wdata_o(led_wdata_o), .busy_o(busy_o),
    .err_o(err_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; btn_i = 1'b0; led_value_i = '0; tx_empty_i = 1'b1;
    rx_avail_i = 1'b0; rx_word_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 tx_valid", 32'(tx_valid_o), 0);
    check("R1 rx_pop",   32'(rx_pop_o), 0);
    check("R1 led_we",   32'(led_we_o), 0);
    check("R1 busy",     32'(busy_o), 0);
    check("R1 flags",    {29'd0, err_o, done_o, timeout_o}, 0);
    @(negedge clk);
  endtask

  // full exchange with queues always ready
  task automatic t_normal(input logic [LED_W-1:0] val);
    btn_i = 1'b1; led_value_i = val; #1;
    check("R10 idle before press", 32'(busy_o), 0);
    next_cyc(); btn_i = 1'b0; #1;
    check("R3 B offered", 32'(tx_valid_o), 1);
    check("R2 B word", tx_word_o, W_BTN);
    check("R10 busy", 32'(busy_o), 1);
    next_cyc(); rx_avail_i = 1'b1; rx_word_i = W_ACK; #1;
    check("R4 pop ack1", 32'(rx_pop_o), 1);
    check("R6 no led in wait", 32'(led_we_o), 0);
    next_cyc(); rx_avail_i = 1'b0; #1;
    check("R5 led write", 32'(led_we_o), 1);
    check("R5 led data", 32'(led_wdata_o), 32'(val));
    next_cyc(); #1;
    check("R5 L offered", 32'(tx_valid_o), 1);
    check("R2 L word", tx_word_o, W_LED);
    check("R5 led once", 32'(led_we_o), 0);
    next_cyc(); rx_avail_i = 1'b1; rx_word_i = W_ACK; #1;
    check("R4 pop ack2", 32'(rx_pop_o), 1);
    next_cyc(); rx_avail_i = 1'b0; #1;
    check("R7 done pulse", 32'(done_o), 1);
    check("R10 idle after", 32'(busy_o), 0);
    next_cyc(); #1;
    check("R7 done single", 32'(done_o), 0);
  endtask

  // outgoing queue full, then incoming queue empty for a while
  task automatic t_hold();
    tx_empty_i = 1'b0; btn_i = 1'b1; led_value_i = 4'h5;
    next_cyc(); btn_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1; check("R3 held while full", 32'(tx_valid_o), 0);
      next_cyc();
    end
    tx_empty_i = 1'b1; #1;
    check("R3 sent when empty", 32'(tx_valid_o), 1);
    next_cyc();
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R4 no pop without data", 32'(rx_pop_o), 0);
      check("R6 no led while waiting", 32'(led_we_o), 0);
      next_cyc();
    end
    rx_avail_i = 1'b1; rx_word_i = W_ACK; next_cyc(); rx_avail_i = 1'b0; #1;
    check("R5 led after late ack", 32'(led_we_o), 1);
    next_cyc(); next_cyc(); rx_avail_i = 1'b1; next_cyc(); rx_avail_i = 1'b0; #1;
    check("R7 done after hold", 32'(done_o), 1);
    next_cyc();
  endtask

  task automatic t_reject(input logic [31:0] bad, input bit at_first, input string tag);
    btn_i = 1'b1; next_cyc(); btn_i = 1'b0;
    next_cyc();
    if (!at_first) begin
      rx_avail_i = 1'b1; rx_word_i = W_ACK; next_cyc(); rx_avail_i = 1'b0;
      next_cyc(); next_cyc();
    end
    rx_avail_i = 1'b1; rx_word_i = bad; #1;
    check({"R8 pop ", tag}, 32'(rx_pop_o), 1);
    next_cyc(); rx_avail_i = 1'b0; #1;
    check({"R8 err ", tag}, 32'(err_o), 1);
    check({"R8 idle ", tag}, 32'(busy_o), 0);
    check({"R6 no led ", tag}, 32'(led_we_o), 0);
    check({"R7 no done ", tag}, 32'(done_o), 0);
    next_cyc(); #1;
    check({"R8 err single ", tag}, 32'(err_o), 0);
    check({"R6 still no led ", tag}, 32'(led_we_o), 0);
  endtask

  task automatic t_timeout();
    btn_i = 1'b1; next_cyc(); btn_i = 1'b0;
    next_cyc();  // now in first reply wait
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk); #1;
    check("R9 busy before limit", 32'(busy_o), 1);
    check("R9 no flag before limit", 32'(timeout_o), 0);
    next_cyc(); #1;
    check("R9 idle at limit", 32'(busy_o), 0);
    check("R9 flag at limit", 32'(timeout_o), 1);
    check("R6 no led on timeout", 32'(led_we_o), 0);
    next_cyc();
    t_normal(4'h3);
    check("R9 flag sticky", 32'(timeout_o), 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal(4'hA);
    t_normal(4'h6);
    t_hold();
    t_reject(W_NACK, 1'b1, "nack");
    t_reject(W_ACK5, 1'b0, "digit");
    t_reject(32'h0141_3341, 1'b1, "term");
    t_timeout();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule